// File: doc/BRIEF.md
# Block Transfer DMA Address and Word Counter

This unit sits between a crate's block-transfer sequencer and host memory. Software first loads a base memory address, a word limit and a termination mode, then issues a start. From then on every data word offered on the input stream is written to memory at the current address. After each write the address moves up by one word, with no processor action per word.

A transfer ends in one of two ways. In counted mode it ends when the programmed number of words has been written. In open mode it ends only when the sequencer asserts its stop line, which happens once the addressed module signals that it has no more data. In counted mode an early stop also ends the block and sets a short-block flag. When the block ends, a one-cycle done pulse is raised. The final address and the number of words moved stay visible until the next start.

Top module: `bxfer_dma_unit`

## Requirements
- R1: A configuration load while idle captures base address, word limit and mode (cfg_open = 1 selects open mode, 0 counted mode). A load while busy is ignored, and the running transfer and the next start both use the previously captured values.
- R2: A start while idle is accepted in open mode, or in counted mode with a nonzero limit. One cycle later busy is high, cur_addr equals the base and word_count is zero.
- R3: Each word with in_valid and in_ready both high causes mem_we in the same cycle, with mem_addr equal to the current address and mem_wdata equal to in_data. After that edge the address and word_count each rise by one, and the address wraps modulo its width.
- R4: In counted mode, at the edge that accepts the limit-th word, busy falls and done rises. done stays high for exactly one cycle, and in_ready is low once busy is low.
- R5: In open mode the transfer ends only on stop. A word accepted in the same cycle as stop is written and counted.
- R6: In counted mode, a stop that ends the block before the limit is reached sets short_blk. short_blk stays clear when the limit is reached, including when stop coincides with the last word, and it is cleared by the next accepted start.
- R7: A start while busy is ignored: the address and word count keep advancing from their current values.
- R8: A start in counted mode with a zero limit starts no transfer. It leaves busy low, produces no done, and raises start_err, which stays high until the next accepted start.
- R9: While idle, in_ready and mem_we are low, and stop or in_valid leave cur_addr and word_count unchanged.
- R10: During reset, busy, done, short_blk, start_err, in_ready and mem_we are low, and cur_addr and word_count are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_load | input | 1 | Capture configuration fields |
| cfg_open | input | 1 | 1 = open mode, 0 = counted mode |
| cfg_base | input | AW | Starting word address |
| cfg_count | input | CW | Word limit for counted mode |
| start | input | 1 | Begin a block transfer |
| stop | input | 1 | End-of-block request from the sequencer |
| in_valid | input | 1 | Input word present |
| in_data | input | DW | Input word |
| in_ready | output | 1 | Unit accepts a word |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | AW | Memory write address |
| mem_wdata | output | DW | Memory write data |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle end-of-block pulse |
| short_blk | output | 1 | Counted block ended early by stop |
| start_err | output | 1 | Start refused for a zero limit |
| cur_addr | output | AW | Current or final address |
| word_count | output | CW | Words moved in the current or last block |

## Verification
The assertions assume that the configuration fields only change the captured state while the unit is idle. They also assume that, in open mode, the sequencer never offers more words than word_count can hold before it asserts stop. The stimulus therefore keeps every open block short, and it only raises stop in a cycle where a word is offered or at a chosen word index. Input gaps are inserted on a fixed pattern, so that address advance is tested both with and without idle cycles between words.

// File: rtl/bxfer_pkg.sv
package bxfer_pkg;
  typedef enum logic {
    XS_IDLE = 1'b0,
    XS_RUN  = 1'b1
  } xfer_state_e;
endpackage

// File: rtl/bxfer_counter.sv
module bxfer_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ld,
  input  logic [W-1:0] ld_val,
  input  logic         inc,
  output logic [W-1:0] q
);
  logic [W-1:0] q_nxt;

  always_comb begin
    q_nxt = q;
    if (ld)       q_nxt = ld_val;
    else if (inc) q_nxt = q + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         q <= '0;
    else if (ld || inc) q <= q_nxt;
  end

  p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !ld) |=> q == $past(q) + W'(1));
  p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ld |=> q == $past(ld_val));
endmodule

// File: rtl/bxfer_cfg_regs.sv
module bxfer_cfg_regs #(
  parameter int AW = 16,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          busy,
  input  logic          open_in,
  input  logic [AW-1:0] base_in,
  input  logic [CW-1:0] limit_in,
  output logic          open_q,
  output logic [AW-1:0] base_q,
  output logic [CW-1:0] limit_q
);
  logic cap_en;
  assign cap_en = load && !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q  <= 1'b0;
      base_q  <= '0;
      limit_q <= '0;
    end else if (cap_en) begin
      open_q  <= open_in;
      base_q  <= base_in;
      limit_q <= limit_in;
    end
  end

  p_cfg_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(base_q) && $stable(limit_q) && $stable(open_q));
endmodule

// File: rtl/bxfer_ctrl.sv
module bxfer_ctrl
  import bxfer_pkg::*;
#(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          stop,
  input  logic          in_valid,
  input  logic          open_mode,
  input  logic [CW-1:0] limit,
  input  logic [CW-1:0] words,
  output logic          busy,
  output logic          accept,
  output logic          start_ok,
  output logic          done,
  output logic          short_blk,
  output logic          start_err
);
  xfer_state_e st_q, st_nxt;
  logic last_word, end_now, start_bad;
  logic done_nxt, short_nxt, err_nxt;

  assign busy      = (st_q == XS_RUN);
  assign accept    = busy && in_valid;
  assign last_word = !open_mode && accept && ((words + CW'(1)) == limit);
  assign end_now   = busy && (stop || last_word);
  assign start_ok  = !busy && start && (open_mode || (limit != '0));
  assign start_bad = !busy && start && !open_mode && (limit == '0);

  always_comb begin
    st_nxt    = st_q;
    done_nxt  = end_now;
    short_nxt = short_blk;
    err_nxt   = start_err;
    if (start_ok) begin
      st_nxt    = XS_RUN;
      short_nxt = 1'b0;
      err_nxt   = 1'b0;
    end else if (start_bad) begin
      err_nxt = 1'b1;
    end
    if (end_now) begin
      st_nxt = XS_IDLE;
      if (!open_mode && !last_word) short_nxt = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= XS_IDLE;
      done      <= 1'b0;
      short_blk <= 1'b0;
      start_err <= 1'b0;
    end else begin
      st_q      <= st_nxt;
      done      <= done_nxt;
      short_blk <= short_nxt;
      start_err <= err_nxt;
    end
  end

  p_done_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_done_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  p_under_limit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !open_mode) |-> words < limit);
  p_short_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(short_blk) |-> $past(stop) && done);
  p_err_no_run_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(start_err) |-> !busy && !done);
endmodule

// File: rtl/bxfer_dma_unit.sv
module bxfer_dma_unit #(
  parameter int AW = 16,
  parameter int CW = 8,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_load,
  input  logic          cfg_open,
  input  logic [AW-1:0] cfg_base,
  input  logic [CW-1:0] cfg_count,
  input  logic          start,
  input  logic          stop,
  input  logic          in_valid,
  input  logic [DW-1:0] in_data,
  output logic          in_ready,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic          busy,
  output logic          done,
  output logic          short_blk,
  output logic          start_err,
  output logic [AW-1:0] cur_addr,
  output logic [CW-1:0] word_count
);
  logic          open_q;
  logic [AW-1:0] base_q;
  logic [CW-1:0] limit_q;
  logic          accept, start_ok;

  bxfer_cfg_regs #(.AW(AW), .CW(CW)) u_cfg (
    .clk(clk), .rst_n(rst_n), .load(cfg_load), .busy(busy),
    .open_in(cfg_open), .base_in(cfg_base), .limit_in(cfg_count),
    .open_q(open_q), .base_q(base_q), .limit_q(limit_q)
  );

  bxfer_ctrl #(.CW(CW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .stop(stop),
    .in_valid(in_valid), .open_mode(open_q), .limit(limit_q),
    .words(word_count), .busy(busy), .accept(accept),
    .start_ok(start_ok), .done(done), .short_blk(short_blk),
    .start_err(start_err)
  );

  bxfer_counter #(.W(AW)) u_addr (
    .clk(clk), .rst_n(rst_n), .ld(start_ok), .ld_val(base_q),
    .inc(accept), .q(cur_addr)
  );

  bxfer_counter #(.W(CW)) u_words (
    .clk(clk), .rst_n(rst_n), .ld(start_ok), .ld_val({CW{1'b0}}),
    .inc(accept), .q(word_count)
  );

  assign in_ready  = busy;
  assign mem_we    = accept;
  assign mem_addr  = cur_addr;
  assign mem_wdata = in_data;

  p_idle_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable(cur_addr) && $stable(word_count));
  p_busy_no_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !in_valid) |=> $stable(cur_addr));
endmodule

// File: tb/bxfer_dma_unit_bench.sv
module bxfer_dma_unit_bench;
  localparam int AW = 16;
  localparam int CW = 8;
  localparam int DW = 16;

  typedef struct packed {
    logic        open;
    logic [15:0] base;
    logic [7:0]  count;
    logic [7:0]  stop_at;   // 8'hFF: no stop
    logic        gaps;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 16'h0100, 8'd4, 8'hFF, 1'b0},
    '{1'b0, 16'h2000, 8'd6, 8'd2,  1'b1},
    '{1'b1, 16'h0040, 8'd0, 8'd4,  1'b0},
    '{1'b1, 16'h1234, 8'd9, 8'd0,  1'b1},
    '{1'b0, 16'h0300, 8'd1, 8'hFF, 1'b0},
    '{1'b0, 16'h0500, 8'd3, 8'd2,  1'b1},
    '{1'b1, 16'hFFFC, 8'd0, 8'd6,  1'b1}
  };

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cfg_load, cfg_open, start, stop, in_valid;
  logic [AW-1:0] cfg_base;
  logic [CW-1:0] cfg_count;
  logic [DW-1:0] in_data;
  logic          in_ready, mem_we, busy, done, short_blk, start_err;
  logic [AW-1:0] mem_addr, cur_addr;
  logic [DW-1:0] mem_wdata;
  logic [CW-1:0] word_count;

  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  bxfer_dma_unit #(.AW(AW), .CW(CW), .DW(DW)) u_bxfer_dma_unit (
    .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_open(cfg_open),
    .cfg_base(cfg_base), .cfg_count(cfg_count), .start(start), .stop(stop),
    .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .busy(busy), .done(done), .short_blk(short_blk), .start_err(start_err),
    .cur_addr(cur_addr), .word_count(word_count)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic load_cfg(input logic op, input logic [15:0] b, input logic [7:0] c);
    @(negedge clk);
    cfg_load = 1'b1; cfg_open = op; cfg_base = b; cfg_count = c;
    @(negedge clk);
    cfg_load = 1'b0;
  endtask

  task automatic pulse_start();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  // feeds words from index w0 until busy drops; stop raised with word index sa
  task automatic feed(input logic [15:0] b, input int w0, input int sa,
                      input logic gaps, output int w);
    int k;
    w = w0; k = 0;
    while (busy && k < 300) begin
      in_valid = gaps ? ((k % 3) != 2) : 1'b1;
      in_data  = 16'hA000 + 16'(w);
      stop     = in_valid && (w == sa);
      #1;
      chk("R3", "in_ready while busy", int'(in_ready), 1);
      if (in_valid) begin
        chk("R3", "mem_we", int'(mem_we), 1);
        chk("R3", "mem_addr", int'(mem_addr), int'(16'(b + 16'(w))));
        chk("R3", "mem_wdata", int'(mem_wdata), int'(in_data));
      end
      @(negedge clk);
      if (in_valid) w++;
      k++;
    end
    in_valid = 1'b0; stop = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    cfg_load = 1'b0; cfg_open = 1'b0; cfg_base = '0; cfg_count = '0;
    start = 1'b0; stop = 1'b0; in_valid = 1'b0; in_data = '0;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10", "busy", int'(busy), 0);
    chk("R10", "done", int'(done), 0);
    chk("R10", "short_blk", int'(short_blk), 0);
    chk("R10", "start_err", int'(start_err), 0);
    chk("R10", "in_ready", int'(in_ready), 0);
    chk("R10", "mem_we", int'(mem_we), 0);
    chk("R10", "cur_addr", int'(cur_addr), 0);
    chk("R10", "word_count", int'(word_count), 0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      int sa, expw, w;
      logic exps;
      sa = (VEC[i].stop_at == 8'hFF) ? -1 : int'(VEC[i].stop_at);
      if (VEC[i].open) expw = sa + 1;
      else if (sa < 0 || sa + 1 >= int'(VEC[i].count)) expw = int'(VEC[i].count);
      else expw = sa + 1;
      exps = !VEC[i].open && sa >= 0 && (sa + 1 < int'(VEC[i].count));
      load_cfg(VEC[i].open, VEC[i].base, VEC[i].count);
      pulse_start();
      chk("R2", "busy after start", int'(busy), 1);
      chk("R2", "cur_addr at start", int'(cur_addr), int'(VEC[i].base));
      chk("R2", "word_count at start", int'(word_count), 0);
      feed(VEC[i].base, 0, sa, VEC[i].gaps, w);
      chk(VEC[i].open ? "R5" : "R4", "words accepted", w, expw);
      chk("R4", "done at end", int'(done), 1);
      chk("R4", "in_ready after end", int'(in_ready), 0);
      chk("R3", "final cur_addr", int'(cur_addr), int'(16'(VEC[i].base + 16'(expw))));
      chk("R3", "final word_count", int'(word_count), expw);
      chk("R6", "short_blk", int'(short_blk), int'(exps));
      @(negedge clk);
      chk("R4", "done one cycle", int'(done), 0);
    end

    // R9: idle ignores stop and in_valid
    begin
      logic [15:0] a0;
      logic [7:0]  c0;
      a0 = cur_addr; c0 = word_count;
      in_valid = 1'b1; stop = 1'b1; in_data = 16'h5555;
      #1;
      chk("R9", "in_ready idle", int'(in_ready), 0);
      chk("R9", "mem_we idle", int'(mem_we), 0);
      @(negedge clk); @(negedge clk);
      in_valid = 1'b0; stop = 1'b0;
      chk("R9", "cur_addr idle", int'(cur_addr), int'(a0));
      chk("R9", "word_count idle", int'(word_count), int'(c0));
      chk("R9", "done idle", int'(done), 0);
    end

    // R1 and R7: load and start while busy are ignored
    begin
      int w;
      load_cfg(1'b0, 16'h0100, 8'd6);
      pulse_start();
      in_valid = 1'b1; in_data = 16'hB000;
      @(negedge clk);
      @(negedge clk);
      in_valid = 1'b0;
      cfg_load = 1'b1; cfg_open = 1'b1; cfg_base = 16'h0F00; cfg_count = 8'd2;
      start = 1'b1;
      @(negedge clk);
      cfg_load = 1'b0; start = 1'b0;
      chk("R7", "busy kept", int'(busy), 1);
      chk("R7", "cur_addr kept", int'(cur_addr), 16'h0102);
      chk("R7", "word_count kept", int'(word_count), 2);
      feed(16'h0100, 2, -1, 1'b0, w);
      chk("R1", "limit unchanged words", w, 6);
      chk("R1", "limit unchanged addr", int'(cur_addr), 16'h0106);
      chk("R1", "counted mode kept, short clear", int'(short_blk), 0);
      @(negedge clk);
      pulse_start();
      chk("R1", "old base reused", int'(cur_addr), 16'h0100);
      feed(16'h0100, 0, 0, 1'b0, w);
      chk("R6", "early stop short", int'(short_blk), 1);
      chk("R6", "early stop words", int'(word_count), 1);
    end

    // R8: zero limit in counted mode
    begin
      load_cfg(1'b0, 16'h0800, 8'd0);
      pulse_start();
      chk("R8", "busy stays low", int'(busy), 0);
      chk("R8", "start_err set", int'(start_err), 1);
      chk("R6", "short held until start", int'(short_blk), 1);
      @(negedge clk); @(negedge clk);
      chk("R8", "no done", int'(done), 0);
      chk("R8", "start_err held", int'(start_err), 1);
      load_cfg(1'b0, 16'h0800, 8'd2);
      pulse_start();
      chk("R8", "start_err cleared", int'(start_err), 0);
      chk("R6", "short cleared by start", int'(short_blk), 0);
      chk("R2", "busy on good start", int'(busy), 1);
      stop = 1'b1;
      @(negedge clk);
      stop = 1'b0;
      chk("R6", "stop before any word short", int'(short_blk), 1);
      chk("R6", "stop before any word count", int'(word_count), 0);
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule